// File: doc/BRIEF.md
# Big-Integer Operand Range Checker

This block screens the four numeric inputs of a signature check before the expensive arithmetic unit is started. Each input is an unsigned big integer held in byte storage, most significant byte at the lowest address. Every input has its own length in bytes, so two operands being compared can differ in size. The block runs four checks in a fixed order: the public key X coordinate must be below the field prime, the Y coordinate must be below the field prime, and each of the two signature halves r and s must be nonzero and below the group order n.

Each check is a sequential compare. The shorter operand is padded with zero bytes at the top, and the block reads one byte of each operand per cycle, starting from the highest position of the longer one. It stops as soon as the answer is known. For r and s, a scan that has already found "less than" keeps reading until it sees a nonzero byte or runs out of bytes. Byte storage sits outside the block behind two read ports. Each port returns data one cycle after the request: one port serves the four candidate operands and the other serves the two bounds. The caller pulses `start` and waits for `done`. It then reads `pass`, or the code of the first check that failed.

Top module: `operand_range_checker`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `cand_rd` and `bound_rd` are 0 and `fail_code` is 0.
- R2: The byte at address 0 of an operand is its most significant byte, and address len-1 holds its least significant byte. Read data is taken one cycle after the read request. `cand_sel` selects 0 = X, 1 = Y, 2 = r, 3 = s, and `bound_sel` selects 0 = prime p, 1 = order n.
- R3: A check compares the operands as unsigned integers, with the shorter one padded by zero bytes at the top. Operands of different lengths therefore compare by value.
- R4: The first differing byte, scanning from the top, decides the order. Equal operands are not "less than", so that check fails.
- R5: Checks run in the order X<p, Y<p, 0<r<n, 0<s<n and stop at the first failure. `fail_code` then equals the failing check's `cand_sel` code.
- R6: An r or s whose bytes are all zero fails its check even though it is below n. This includes an operand of length 0.
- R7: `done` is a one-cycle pulse. `pass` is 1 only when all four checks hold. `pass` and `fail_code` keep their values until the next accepted `start`.
- R8: A check ends at the first deciding byte: for X and Y, the first differing byte; for r and s, the byte by which both "less than" and "nonzero" are known. A check that ends on its first scanned byte takes 4 cycles, so when all four end that way, `done` rises 16 cycles after the `start` edge, whatever the operand lengths.
- R9: `start` while `busy` is 1 is ignored: the result and the timing of the run in progress do not change.
- R10: A read request is issued only for an address below the selected operand's length. Padded positions are never read.
- R11: Operand lengths are 0 to MAX_BYTES (66 by default, enough for a 521-bit modulus).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a four-check run (pulse) |
| x_len | input | LEN_W | Byte length of public key X |
| y_len | input | LEN_W | Byte length of public key Y |
| r_len | input | LEN_W | Byte length of signature r |
| s_len | input | LEN_W | Byte length of signature s |
| p_len | input | LEN_W | Byte length of field prime p |
| n_len | input | LEN_W | Byte length of group order n |
| cand_rd | output | 1 | Candidate read request |
| cand_sel | output | 2 | Candidate operand select (0 X, 1 Y, 2 r, 3 s) |
| cand_addr | output | LEN_W | Candidate byte address (0 = most significant) |
| cand_data | input | 8 | Candidate byte, one cycle after request |
| bound_rd | output | 1 | Bound read request |
| bound_sel | output | 1 | Bound operand select (0 p, 1 n) |
| bound_addr | output | LEN_W | Bound byte address (0 = most significant) |
| bound_data | input | 8 | Bound byte, one cycle after request |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run ends |
| pass | output | 1 | All four checks held |
| fail_code | output | 2 | Code of the first failing check |

## Verification
In the r and s checks, two decisions can fall on the same byte: the order decision (candidate below bound) and the nonzero detection. When both land on the top byte, the scan must end in that cycle. When the order is decided on a zero top byte, the scan must continue until a nonzero lower byte arrives. The bench provokes both cases. One case uses r and s whose top bytes are small and nonzero, and it is judged by the 16-cycle total. Another uses r = 00 00 03 against n = 05 00 00, and it must pass. Two all-zero values (length 2 and length 0) must fail with code 2.

// File: rtl/rc_pkg.sv
package rc_pkg;
    typedef logic [1:0] chk_t;
    localparam chk_t CHK_X = 2'd0;
    localparam chk_t CHK_Y = 2'd1;
    localparam chk_t CHK_R = 2'd2;
    localparam chk_t CHK_S = 2'd3;
    localparam logic BND_P = 1'b0;
    localparam logic BND_N = 1'b1;
endpackage

// File: rtl/rc_len_mux.sv
module rc_len_mux
    import rc_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input  chk_t             chk,
    input  logic [LEN_W-1:0] x_len,
    input  logic [LEN_W-1:0] y_len,
    input  logic [LEN_W-1:0] r_len,
    input  logic [LEN_W-1:0] s_len,
    input  logic [LEN_W-1:0] p_len,
    input  logic [LEN_W-1:0] n_len,
    output logic [LEN_W-1:0] cand_len,
    output logic [LEN_W-1:0] bound_len,
    output logic             bound_sel,
    output logic             need_nz
);
    always_comb begin
        unique case (chk)
            CHK_X:   cand_len = x_len;
            CHK_Y:   cand_len = y_len;
            CHK_R:   cand_len = r_len;
            default: cand_len = s_len;
        endcase
        // the two signature checks compare against n and demand nonzero
        bound_sel = (chk == CHK_R || chk == CHK_S) ? BND_N : BND_P;
        bound_len = (bound_sel == BND_N) ? n_len : p_len;
        need_nz   = (bound_sel == BND_N);
    end
endmodule

// File: rtl/rc_scan.sv
module rc_scan #(
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [LEN_W-1:0] len_a,
    input  logic [LEN_W-1:0] len_b,
    input  logic             need_nz,
    output logic             a_rd,
    output logic [LEN_W-1:0] a_addr,
    input  logic [7:0]       a_data,
    output logic             b_rd,
    output logic [LEN_W-1:0] b_addr,
    input  logic [7:0]       b_data,
    output logic             fin,
    output logic             ok
);
    typedef struct packed {
        logic             busy;
        logic             issuing;
        logic [LEN_W-1:0] k;      // significance index being requested
        logic [LEN_W-1:0] la;
        logic [LEN_W-1:0] lb;
        logic             need_nz;
        logic             vld;    // read data for a requested index arrives
        logic             pad_a;
        logic             pad_b;
        logic             last;
        logic             lt;
        logic             nz;
        logic             fin;
        logic             ok;
    } scan_t;

    scan_t q, d;

    logic [7:0]       a_byte, b_byte;
    logic             lt_now, gt_now, nz_now, win;
    logic [LEN_W-1:0] top_len;

    always_comb begin
        top_len = (len_a > len_b) ? len_a : len_b;
        a_byte  = q.pad_a ? 8'h00 : a_data;
        b_byte  = q.pad_b ? 8'h00 : b_data;
        lt_now  = q.lt | (a_byte < b_byte);
        gt_now  = !q.lt && (a_byte > b_byte);
        nz_now  = q.nz | (a_byte != 8'h00);
        win     = lt_now && (!q.need_nz || nz_now);

        d     = q;
        d.fin = 1'b0;
        d.vld = 1'b0;
        if (!q.busy) begin
            if (go) begin
                d.la      = len_a;
                d.lb      = len_b;
                d.need_nz = need_nz;
                d.lt      = 1'b0;
                d.nz      = 1'b0;
                d.ok      = 1'b0;
                if (top_len == '0) begin
                    d.fin = 1'b1;
                end else begin
                    d.busy    = 1'b1;
                    d.issuing = 1'b1;
                    d.k       = top_len - LEN_W'(1);
                end
            end
        end else begin
            if (q.issuing) begin
                d.vld   = 1'b1;
                d.pad_a = (q.k >= q.la);
                d.pad_b = (q.k >= q.lb);
                d.last  = (q.k == '0);
                if (q.k == '0) d.issuing = 1'b0;
                else           d.k = q.k - LEN_W'(1);
            end
            if (q.vld) begin
                d.lt = lt_now;
                d.nz = nz_now;
                if (gt_now || win || q.last) begin
                    d.busy    = 1'b0;
                    d.issuing = 1'b0;
                    d.vld     = 1'b0;
                    d.fin     = 1'b1;
                    d.ok      = win;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign a_rd   = q.busy && q.issuing && (q.k < q.la);
    assign b_rd   = q.busy && q.issuing && (q.k < q.lb);
    assign a_addr = q.la - q.k - LEN_W'(1);
    assign b_addr = q.lb - q.k - LEN_W'(1);
    assign fin    = q.fin;
    assign ok     = q.ok;

    // R10: requests stay inside the operand
    a_r10_cand_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        a_rd |-> (a_addr < q.la));
    a_r10_bound_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        b_rd |-> (b_addr < q.lb));
    // R8: a finish always closes an active scan or a zero-length start
    a_r8_fin_follows_activity: assert property (@(posedge clk) disable iff (!rst_n)
        q.fin |-> ($past(q.busy) || $past(go)));
    // R4: success needs a strict less-than decision
    a_r4_ok_needs_less: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fin && q.ok) |-> q.lt);
    // R6: success on a nonzero-demanding check needs a nonzero byte seen
    a_r6_ok_needs_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fin && q.ok && q.need_nz) |-> q.nz);
endmodule

// File: rtl/rc_seq.sv
module rc_seq
    import rc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic fin,
    input  logic ok,
    output logic go,
    output chk_t chk,
    output logic busy,
    output logic done,
    output logic pass,
    output chk_t fail_code
);
    typedef struct packed {
        logic busy;
        chk_t chk;
        logic go;
        logic done;
        logic pass;
        chk_t code;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d      = q;
        d.go   = 1'b0;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.chk  = CHK_X;
                d.go   = 1'b1;
                d.pass = 1'b0;
                d.code = CHK_X;
            end
        end else if (fin) begin
            if (!ok) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.pass = 1'b0;
                d.code = q.chk;
            end else if (q.chk == CHK_S) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.pass = 1'b1;
                d.code = CHK_X;
            end else begin
                d.chk = q.chk + 2'd1;
                d.go  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign go        = q.go;
    assign chk       = q.chk;
    assign busy      = q.busy;
    assign done      = q.done;
    assign pass      = q.pass;
    assign fail_code = q.code;

    // R7: done lasts a single cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
    // R5: a pass only after the last check
    a_r5_pass_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.pass) |-> (q.chk == CHK_S));
    // R5: failure code names the check in progress
    a_r5_code_is_check: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && !q.pass) |-> (q.code == q.chk));
    // R9: a start during a run does not restart the check order
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && start && !fin) |=> $stable(q.chk));
endmodule

// File: rtl/operand_range_checker.sv
module operand_range_checker
    import rc_pkg::*;
#(
    parameter int MAX_BYTES = 66,
    localparam int LEN_W = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] x_len,
    input  logic [LEN_W-1:0] y_len,
    input  logic [LEN_W-1:0] r_len,
    input  logic [LEN_W-1:0] s_len,
    input  logic [LEN_W-1:0] p_len,
    input  logic [LEN_W-1:0] n_len,
    output logic             cand_rd,
    output logic [1:0]       cand_sel,
    output logic [LEN_W-1:0] cand_addr,
    input  logic [7:0]       cand_data,
    output logic             bound_rd,
    output logic             bound_sel,
    output logic [LEN_W-1:0] bound_addr,
    input  logic [7:0]       bound_data,
    output logic             busy,
    output logic             done,
    output logic             pass,
    output logic [1:0]       fail_code
);
    chk_t             chk;
    logic             go, fin, ok, need_nz;
    logic [LEN_W-1:0] cand_len, bound_len;

    rc_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .fin       (fin),
        .ok        (ok),
        .go        (go),
        .chk       (chk),
        .busy      (busy),
        .done      (done),
        .pass      (pass),
        .fail_code (fail_code)
    );

    rc_len_mux #(.LEN_W(LEN_W)) u_mux (
        .chk       (chk),
        .x_len     (x_len),
        .y_len     (y_len),
        .r_len     (r_len),
        .s_len     (s_len),
        .p_len     (p_len),
        .n_len     (n_len),
        .cand_len  (cand_len),
        .bound_len (bound_len),
        .bound_sel (bound_sel),
        .need_nz   (need_nz)
    );

    rc_scan #(.LEN_W(LEN_W)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .len_a   (cand_len),
        .len_b   (bound_len),
        .need_nz (need_nz),
        .a_rd    (cand_rd),
        .a_addr  (cand_addr),
        .a_data  (cand_data),
        .b_rd    (bound_rd),
        .b_addr  (bound_addr),
        .b_data  (bound_data),
        .fin     (fin),
        .ok      (ok)
    );

    assign cand_sel = chk;

    // R11: lengths within the configured maximum while a run is active
    a_r11_len_limit: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cand_len <= LEN_W'(MAX_BYTES) && bound_len <= LEN_W'(MAX_BYTES)));
endmodule

// File: tb/operand_range_checker_test.sv
module operand_range_checker_test;
    localparam int MB = 66;
    localparam int LW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [LW-1:0] x_len = '0, y_len = '0, r_len = '0, s_len = '0, p_len = '0, n_len = '0;
    logic cand_rd, bound_rd, bound_sel, busy, done, pass;
    logic [1:0] cand_sel, fail_code;
    logic [LW-1:0] cand_addr, bound_addr;
    logic [7:0] cand_data = 8'h00, bound_data = 8'h00;

    int checks = 0;
    int errors = 0;
    int addr_viol = 0;

    logic [7:0] cmem [4][MB];
    logic [7:0] bmem [2][MB];
    logic [8*MB-1:0] val_c [4];
    logic [8*MB-1:0] val_b [2];

    always #10 clk = ~clk;

    operand_range_checker uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .x_len(x_len), .y_len(y_len), .r_len(r_len), .s_len(s_len),
        .p_len(p_len), .n_len(n_len),
        .cand_rd(cand_rd), .cand_sel(cand_sel), .cand_addr(cand_addr), .cand_data(cand_data),
        .bound_rd(bound_rd), .bound_sel(bound_sel), .bound_addr(bound_addr), .bound_data(bound_data),
        .busy(busy), .done(done), .pass(pass), .fail_code(fail_code)
    );

    function automatic int clen(input int sel);
        case (sel)
            0: clen = int'(x_len);
            1: clen = int'(y_len);
            2: clen = int'(r_len);
            default: clen = int'(s_len);
        endcase
    endfunction

    // byte storage with one-cycle read latency; R10 address monitor
    always @(posedge clk) begin
        if (cand_rd) begin
            if (int'(cand_addr) >= clen(int'(cand_sel))) addr_viol++;
            else cand_data <= cmem[cand_sel][cand_addr];
        end
        if (bound_rd) begin
            if (int'(bound_addr) >= (bound_sel ? int'(n_len) : int'(p_len))) addr_viol++;
            else bound_data <= bmem[bound_sel][bound_addr];
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R2: address 0 holds the most significant byte
    task automatic load_c(input int sel, input int len, input logic [8*MB-1:0] v);
        for (int i = 0; i < len; i++) cmem[sel][i] = v[8*(len-1-i) +: 8];
        val_c[sel] = v;
        case (sel)
            0: x_len = LW'(len);
            1: y_len = LW'(len);
            2: r_len = LW'(len);
            default: s_len = LW'(len);
        endcase
    endtask

    task automatic load_b(input int sel, input int len, input logic [8*MB-1:0] v);
        for (int i = 0; i < len; i++) bmem[sel][i] = v[8*(len-1-i) +: 8];
        val_b[sel] = v;
        if (sel == 0) p_len = LW'(len);
        else          n_len = LW'(len);
    endtask

    // independent reference from the requirements
    task automatic expect_result(output int ep, output int ec);
        ep = 0;
        if (!(val_c[0] < val_b[0]))                            ec = 0;
        else if (!(val_c[1] < val_b[0]))                       ec = 1;
        else if (!(val_c[2] != 0 && val_c[2] < val_b[1]))      ec = 2;
        else if (!(val_c[3] != 0 && val_c[3] < val_b[1]))      ec = 3;
        else begin ep = 1; ec = 0; end
    endtask

    task automatic run(input string req, input int exp_cycles, input bit poke);
        int ep, ec, cnt;
        bit seen;
        expect_result(ep, ec);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        cnt = 0;
        seen = 1'b0;
        while (!seen && cnt < 5000) begin
            @(posedge clk);
            cnt++;
            #1;
            if (poke) start = (cnt == 3);
            if (done) seen = 1'b1;
        end
        start = 1'b0;
        check({req, " done seen"}, int'(seen), 1);
        check({req, " pass"}, int'(pass), ep);
        if (ep == 0) check({req, " fail_code"}, int'(fail_code), ec);
        if (exp_cycles > 0) check({req, " cycles"}, cnt, exp_cycles);
        @(posedge clk); #1;
        check("R7 done one cycle", int'(done), 0);
        repeat (3) @(posedge clk);
        #1;
        check("R7 pass held", int'(pass), ep);
        check("R7 code held", int'(fail_code), ep ? 0 : ec);
    endtask

    task automatic t_reset;
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 pass", int'(pass), 0);
        check("R1 fail_code", int'(fail_code), 0);
        check("R1 reads", int'(cand_rd | bound_rd), 0);
    endtask

    task automatic base_pass;
        load_b(0, 1, 'h05);
        load_b(1, 1, 'h05);
        load_c(0, 1, 'h01);
        load_c(1, 1, 'h01);
        load_c(2, 1, 'h01);
        load_c(3, 1, 'h01);
    endtask

    task automatic t_fast_pass;
        base_pass();
        run("R8 short operands", 16, 1'b0);
    endtask

    task automatic t_long_early;
        logic [8*MB-1:0] c, b;
        c = '0; b = '0;
        c[8*MB-1 -: 8] = 8'h01; c[7:0] = 8'hFF;
        b[8*MB-1 -: 8] = 8'h02;
        load_b(0, MB, b); load_b(1, MB, b);
        for (int i = 0; i < 4; i++) load_c(i, MB, c);
        run("R8 66-byte early stop", 16, 1'b0);
    endtask

    task automatic t_x_greater;
        base_pass();
        load_c(0, 2, 'h1234);
        load_b(0, 2, 'h1233);
        run("R3 R5 X above p", 0, 1'b0);
    endtask

    task automatic t_y_equal;
        base_pass();
        load_b(0, 3, 'hA1B2C3);
        load_c(0, 2, 'h00FF);
        load_c(1, 3, 'hA1B2C3);
        run("R4 Y equal p", 0, 1'b0);
    endtask

    task automatic t_padding;
        base_pass();
        load_c(0, 4, 'h00000009);
        load_b(0, 1, 'h05);
        run("R3 padded bound", 0, 1'b0);
        base_pass();
        load_c(0, 1, 'hFF);
        load_b(0, 3, 'h010000);
        run("R3 padded candidate", 0, 1'b0);
    endtask

    task automatic t_r_zero;
        base_pass();
        load_c(2, 2, 'h0000);
        run("R6 r zero", 0, 1'b0);
        base_pass();
        load_c(2, 0, 'h0);
        run("R6 r empty", 0, 1'b0);
    endtask

    task automatic t_s_cases;
        base_pass();
        load_c(3, 1, 'h05);
        run("R4 R5 s equal n", 0, 1'b0);
        base_pass();
        load_b(1, 2, 'h0100);
        load_c(2, 1, 'h7F);
        load_c(3, 2, 'h0101);
        run("R5 s above n", 0, 1'b0);
    endtask

    task automatic t_late_nonzero;
        base_pass();
        load_b(1, 3, 'h050000);
        load_c(2, 3, 'h000003);
        load_c(3, 3, 'h000000);
        run("R6 s zero after late r", 0, 1'b0);
        load_c(3, 3, 'h000100);
        run("R6 late nonzero passes", 0, 1'b0);
    endtask

    task automatic t_restart;
        base_pass();
        run("R9 start while busy", 16, 1'b1);
    endtask

    initial begin
        for (int s = 0; s < 4; s++) for (int i = 0; i < MB; i++) cmem[s][i] = 8'h00;
        for (int s = 0; s < 2; s++) for (int i = 0; i < MB; i++) bmem[s][i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 t_reset();
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_fast_pass();
        t_long_early();
        t_x_greater();
        t_y_equal();
        t_padding();
        t_r_zero();
        t_s_cases();
        t_late_nonzero();
        t_restart();
        check("R10 reads in range", addr_viol, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule